// File: doc/BRIEF.md
# Parity-Banked 2x2 Window Frame Store

This block holds one grayscale frame in on-chip memory and serves a bilinear-style interpolator that works by inverse mapping. Pixels arrive one per clock in raster order and are written as they come. On the same clock, the interpolator may name any pixel as the top-left corner of a 2x2 square. Two cycles later the block returns all four pixels of that square in one 32-bit word. Requests may be issued back to back at full clock rate, in any order of positions.

Only a single copy of the frame is kept. Storage is split into four banks by the parity of the row and the column. Any 2x2 square covers one even and one odd column and one even and one odd row, so it touches each bank exactly once. The block generates the write position, works out a read address for each bank from the requested corner, and steers the bank outputs into fixed lane order. Frame size is set by parameters. The target configuration is 320 by 240. The default in the source is a small frame so that it elaborates quickly. Both dimensions must be even.

Top module: `pxq_quad_mem`

## Requirements
- R1: Written pixels fill the frame in raster order. The n-th accepted pixel after reset goes to column n mod IMG_W and row (n div IMG_W) mod IMG_H. After the last pixel of a frame, the next accepted pixel goes back to column 0, row 0.
- R2: A request at corner (x0,y0) with x0 < IMG_W-1 and y0 < IMG_H-1 returns pixel (x0,y0) in bits [7:0] (top-left), (x0+1,y0) in bits [15:8] (top-right), (x0,y0+1) in bits [23:16] (bottom-left) and (x0+1,y0+1) in bits [31:24] (bottom-right). This holds for all four parity combinations of x0 and y0.
- R3: One request is accepted on every clock that `rd_req` is high. Back-to-back requests each get their own correct answer, with no stall and no lost request.
- R4: `rd_valid` is high exactly two clocks after a clock on which `rd_req` was high, and low otherwise. `rd_quad` carries that request's data in the same cycle.
- R5: When x0 = IMG_W-1, the right-hand neighbour is clamped to the last column, so the top-right lane equals top-left and the bottom-right lane equals bottom-left.
- R6: When y0 = IMG_H-1, the lower neighbour is clamped to the last row, so the bottom-left lane equals top-left and the bottom-right lane equals top-right.
- R7: At the corner (IMG_W-1, IMG_H-1), all four lanes carry that one pixel.
- R8: Synchronous active-high reset clears the read pipeline, so `rd_valid` is low after reset. It also returns the write position to column 0, row 0, even in the middle of a frame.
- R9: A clock with `wr_valid` low writes nothing and does not advance the write position, whatever `wr_pixel` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes and reads |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Pixel on `wr_pixel` is stored this clock |
| wr_pixel | input | 8 | Incoming gray level, raster order |
| rd_req | input | 1 | Request a 2x2 window this clock |
| rd_x | input | $clog2(IMG_W) | Column of the window's top-left corner |
| rd_y | input | $clog2(IMG_H) | Row of the window's top-left corner |
| rd_valid | output | 1 | `rd_quad` holds the answer to the request two clocks earlier |
| rd_quad | output | 32 | Lanes TL [7:0], TR [15:8], BL [23:16], BR [31:24] |

## Verification
The bench sweeps every corner position of an 8 by 6 frame. The expected windows are computed from its own copy of the written image. A lane crossbar keyed on the wrong parity bit would swap TL with TR, or top with bottom, only at odd corners, so all four parity cases are swept. Edge requests catch a neighbour that wraps into the next row or into bank address 0 instead of clamping. Write gaps carrying junk data, a reset in the middle of a frame, and a second frame written after the first show a write counter that advances on idle cycles, keeps its position across reset, or fails to wrap. Reads are issued both back to back and with idle cycles between them, so a valid flag with the wrong delay shows up as data paired with the wrong request.

// File: rtl/pxq_pkg.sv
package pxq_pkg;

    localparam int unsigned PIX_W = 8;
    localparam int unsigned LANES = 4;

    typedef logic [PIX_W-1:0] pix_t;

    // First member lands in the most significant bits.
    typedef struct packed {
        pix_t br;
        pix_t bl;
        pix_t tr;
        pix_t tl;
    } quad_t;

    typedef logic [1:0] bank_id_t;

    typedef enum logic [1:0] {
        LANE_TL = 2'd0,
        LANE_TR = 2'd1,
        LANE_BL = 2'd2,
        LANE_BR = 2'd3
    } lane_e;

    // Bank chosen by row parity (high bit) and column parity (low bit).
    function automatic bank_id_t bank_of(input logic col_lsb, input logic row_lsb);
        return {row_lsb, col_lsb};
    endfunction

endpackage

// File: rtl/pxq_wr_seq.sv
module pxq_wr_seq
    import pxq_pkg::*;
#(
    parameter int unsigned IMG_W = 32,
    parameter int unsigned IMG_H = 24,
    parameter int unsigned XW    = 5,
    parameter int unsigned YW    = 5,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y,
    output bank_id_t      wr_bank,
    output logic [AW-1:0] wr_addr
);

    localparam int unsigned HALF_W = IMG_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (wr_valid) begin
            if (cur_x == XW'(IMG_W - 1)) begin
                cur_x <= '0;
                if (cur_y == YW'(IMG_H - 1)) begin
                    cur_y <= '0;
                end else begin
                    cur_y <= cur_y + 1'b1;
                end
            end else begin
                cur_x <= cur_x + 1'b1;
            end
        end
    end

    always_comb begin
        wr_bank = bank_of(cur_x[0], cur_y[0]);
        wr_addr = AW'((int'(cur_y) / 2) * HALF_W + (int'(cur_x) / 2));
    end

endmodule

// File: rtl/pxq_rd_map.sv
module pxq_rd_map
    import pxq_pkg::*;
#(
    parameter int unsigned IMG_W = 32,
    parameter int unsigned IMG_H = 24,
    parameter int unsigned XW    = 5,
    parameter int unsigned YW    = 5,
    parameter int unsigned AW    = 8
) (
    input  logic [XW-1:0]                req_x,
    input  logic [YW-1:0]                req_y,
    output logic [LANES-1:0][AW-1:0]     bank_addr,
    output logic [LANES-1:0][1:0]        lane_bank
);

    localparam int unsigned HALF_W = IMG_W / 2;
    localparam int          LAST_X = int'(IMG_W) - 1;
    localparam int          LAST_Y = int'(IMG_H) - 1;

    int xa;
    int xb;
    int ya;
    int yb;
    int lx [LANES];
    int ly [LANES];
    logic [LANES-1:0][AW-1:0] lane_addr;

    always_comb begin
        // Corner itself is held inside the frame, then the neighbour clamps.
        xa = (int'(req_x) > LAST_X) ? LAST_X : int'(req_x);
        ya = (int'(req_y) > LAST_Y) ? LAST_Y : int'(req_y);
        xb = (xa == LAST_X) ? xa : xa + 1;
        yb = (ya == LAST_Y) ? ya : ya + 1;

        lx[LANE_TL] = xa; ly[LANE_TL] = ya;
        lx[LANE_TR] = xb; ly[LANE_TR] = ya;
        lx[LANE_BL] = xa; ly[LANE_BL] = yb;
        lx[LANE_BR] = xb; ly[LANE_BR] = yb;

        for (int k = 0; k < LANES; k++) begin
            lane_bank[k] = bank_of(lx[k][0], ly[k][0]);
            lane_addr[k] = AW'((ly[k] / 2) * HALF_W + (lx[k] / 2));
        end

        // Each bank takes the address of the lane that lands on it. Clamped
        // lanes share a bank and then also share the same address.
        bank_addr = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            bank_addr[lane_bank[k]] = lane_addr[k];
        end
    end

endmodule

// File: rtl/pxq_bank.sv
module pxq_bank
    import pxq_pkg::*;
#(
    parameter int unsigned DEPTH = 192,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  pix_t          wd,
    input  logic [AW-1:0] ra,
    output pix_t          rq
);

    pix_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[wa] <= wd;
        end
        rq <= store[ra];
    end

endmodule

// File: rtl/pxq_quad_mem.sv
module pxq_quad_mem
    import pxq_pkg::*;
#(
    parameter int unsigned IMG_W  = 32,
    parameter int unsigned IMG_H  = 24,
    localparam int unsigned XW     = $clog2(IMG_W),
    localparam int unsigned YW     = $clog2(IMG_H),
    localparam int unsigned HALF_W = IMG_W / 2,
    localparam int unsigned HALF_H = IMG_H / 2,
    localparam int unsigned DEPTH  = HALF_W * HALF_H,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_valid,
    input  logic [PIX_W-1:0]       wr_pixel,
    input  logic                   rd_req,
    input  logic [XW-1:0]          rd_x,
    input  logic [YW-1:0]          rd_y,
    output logic                   rd_valid,
    output logic [LANES*PIX_W-1:0] rd_quad
);

    logic [XW-1:0] wr_x;
    logic [YW-1:0] wr_y;
    bank_id_t      wr_bank;
    logic [AW-1:0] wr_addr;

    pxq_wr_seq #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .AW(AW)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .cur_x   (wr_x),
        .cur_y   (wr_y),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr)
    );

    logic [LANES-1:0][AW-1:0] map_addr;
    logic [LANES-1:0][1:0]    map_lane;

    pxq_rd_map #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .AW(AW)
    ) u_map (
        .req_x    (rd_x),
        .req_y    (rd_y),
        .bank_addr(map_addr),
        .lane_bank(map_lane)
    );

    // Stage 1: bank addresses and lane steering registered.
    logic                     v1;
    logic [LANES-1:0][AW-1:0] addr1;
    logic [LANES-1:0][1:0]    lane1;
    // Stage 2: bank data registered inside each bank.
    logic                     v2;
    logic [LANES-1:0][1:0]    lane2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= rd_req;
            v2 <= v1;
        end
    end

    always_ff @(posedge clk) begin
        addr1 <= map_addr;
        lane1 <= map_lane;
        lane2 <= lane1;
    end

    logic [LANES-1:0][PIX_W-1:0] bank_q;

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        pxq_bank #(
            .DEPTH(DEPTH), .AW(AW)
        ) u_bank (
            .clk(clk),
            .we (wr_valid && (wr_bank == bank_id_t'(b))),
            .wa (wr_addr),
            .wd (wr_pixel),
            .ra (addr1[b]),
            .rq (bank_q[b])
        );
    end

    quad_t out_q;

    always_comb begin
        out_q.tl = bank_q[lane2[LANE_TL]];
        out_q.tr = bank_q[lane2[LANE_TR]];
        out_q.bl = bank_q[lane2[LANE_BL]];
        out_q.br = bank_q[lane2[LANE_BR]];
        rd_quad  = out_q;
        rd_valid = v2;
    end

endmodule

// File: rtl/pxq_chk.sv
module pxq_chk
    import pxq_pkg::*;
#(
    parameter int unsigned IMG_W = 32,
    parameter int unsigned IMG_H = 24,
    localparam int unsigned XW   = $clog2(IMG_W),
    localparam int unsigned YW   = $clog2(IMG_H)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_valid,
    input logic [XW-1:0]          wr_x,
    input logic [YW-1:0]          wr_y,
    input logic                   rd_req,
    input logic [XW-1:0]          rd_x,
    input logic [YW-1:0]          rd_y,
    input logic                   rd_valid,
    input logic [LANES*PIX_W-1:0] rd_quad
);

    logic [1:0] since_rst;
    quad_t      q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    assign q = rd_quad;

    // R8
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 2'd2) |-> !rd_valid);

    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rd_valid == $past(rd_req, 2)));

    // R5
    right_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd2) && $past(rd_req && (rd_x == XW'(IMG_W - 1)), 2))
        |-> ((q.tr == q.tl) && (q.br == q.bl)));

    // R6
    bottom_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd2) && $past(rd_req && (rd_y == YW'(IMG_H - 1)), 2))
        |-> ((q.bl == q.tl) && (q.br == q.tr)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd1) && !$past(wr_valid)) |-> ($stable(wr_x) && $stable(wr_y)));

    // R1
    raster_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd1) && $past(wr_valid) && ($past(wr_x) != XW'(IMG_W - 1)))
        |-> ((wr_x == $past(wr_x) + 1'b1) && $stable(wr_y)));

    // R1
    raster_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 2'd1) && $past(wr_valid) && ($past(wr_x) == XW'(IMG_W - 1)))
        |-> (wr_x == '0));

endmodule

bind pxq_quad_mem pxq_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_valid(wr_valid),
    .wr_x    (wr_x),
    .wr_y    (wr_y),
    .rd_req  (rd_req),
    .rd_x    (rd_x),
    .rd_y    (rd_y),
    .rd_valid(rd_valid),
    .rd_quad (rd_quad)
);

// File: tb/test_pxq_quad_mem.sv
module test_pxq_quad_mem;
    import pxq_pkg::*;

    localparam int W  = 8;
    localparam int H  = 6;
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_pixel = '0;
    logic          rd_req = 1'b0;
    logic [XW-1:0] rd_x = '0;
    logic [YW-1:0] rd_y = '0;
    logic          rd_valid;
    logic [31:0]   rd_quad;

    always #4 clk = ~clk;

    pxq_quad_mem #(.IMG_W(W), .IMG_H(H)) i_pxq_quad_mem (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_pixel(wr_pixel),
        .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
        .rd_valid(rd_valid), .rd_quad(rd_quad)
    );

    logic [7:0] img [H][W];
    int mx = 0;
    int my = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R2";

    function automatic logic [7:0] pv(int seed, int x, int y);
        return 8'(y * W + x + seed * 97);
    endfunction

    function automatic logic [31:0] expq(int x, int y);
        int xb;
        int yb;
        xb = (x >= W - 1) ? W - 1 : x + 1;
        yb = (y >= H - 1) ? H - 1 : y + 1;
        return {img[yb][xb], img[yb][x], img[y][xb], img[y][x]};
    endfunction

    function automatic string edge_tag(int x, int y);
        if (x == W - 1 && y == H - 1) return "R7";
        if (x == W - 1) return "R5";
        if (y == H - 1) return "R6";
        return "R2";
    endfunction

    // Expected-result pipeline: two clocks from request to answer (R4).
    logic        h1v, h2v;
    logic [31:0] h1q, h2q;
    string       h1t, h2t;

    always @(posedge clk) begin
        if (rst) begin
            h1v <= 1'b0;
            h2v <= 1'b0;
        end else begin
            h1v <= rd_req;
            h1q <= expq(int'(rd_x), int'(rd_y));
            h1t <= {phase, "/", edge_tag(int'(rd_x), int'(rd_y))};
            h2v <= h1v;
            h2q <= h1q;
            h2t <= h1t;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done && (h2v || rd_valid)) begin
            n_chk++;
            if (rd_valid !== h2v) begin
                n_bad++;
                $display("FAIL R4 rd_valid got %b exp %b", rd_valid, h2v);
            end else begin
                n_chk++;
                if (rd_quad !== h2q) begin
                    n_bad++;
                    $display("FAIL %s rd_quad got %h exp %h", h2t, rd_quad, h2q);
                end
            end
        end
    end

    task automatic put_pix(input int seed, input bit v);
        @(negedge clk);
        rd_req   = 1'b0;
        wr_valid = v;
        if (v) begin
            wr_pixel = pv(seed, mx, my);
            img[my][mx] = wr_pixel;
            mx++;
            if (mx == W) begin
                mx = 0;
                my = (my == H - 1) ? 0 : my + 1;
            end
        end else begin
            wr_pixel = 8'hEE;
        end
    endtask

    task automatic ask(input int x, input int y, input bit v);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_req   = v;
        rd_x     = XW'(x);
        rd_y     = YW'(y);
    endtask

    task automatic check_quiet(input string tag);
        n_chk++;
        if (rd_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s rd_valid got %b exp 0", tag, rd_valid);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_quiet("R8");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R8");

        // Partial frame, then reset mid-frame: position must return to origin (R8).
        for (int i = 0; i < 10; i++) put_pix(99, 1'b1);
        @(negedge clk);
        wr_valid = 1'b0;
        rst = 1'b1;
        mx = 0;
        my = 0;
        @(negedge clk);
        check_quiet("R8");
        rst = 1'b0;

        // Frame A with idle gaps carrying junk (R9).
        for (int i = 0; i < W * H; i++) begin
            if (i % 3 == 1) put_pix(1, 1'b0);
            put_pix(1, 1'b1);
        end
        put_pix(1, 1'b0);

        // Every corner back to back (R2, R3, R5, R6, R7).
        phase = "R3";
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                ask(x, y, 1'b1);
        ask(0, 0, 1'b0);
        repeat (3) @(negedge clk);

        // Frame B follows straight on from A: writes wrap to origin (R1).
        for (int i = 0; i < W * H; i++) put_pix(2, 1'b1);
        put_pix(2, 1'b0);

        phase = "R1";
        for (int i = W * H - 1; i >= 0; i--) begin
            ask(i % W, i / W, 1'b1);
            if (i % 4 == 0) ask(W - 1, H - 1, 1'b0);
        end
        ask(0, 0, 1'b0);
        repeat (4) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule